// File: doc/BRIEF.md
# Four-Channel Fading PWM Dimmer

The block drives four LED outputs, each through an 8-bit pulse-width modulator that shares one free-running period counter. Every channel takes a target duty byte and has three controls of its own: an output enable, a fade enable and a curve select. One global enable gates the whole block. A single 4-bit time code chooses how long a fade lasts. When fading is active for a channel, a new target is approached one LSB at a time, so the whole change takes the coded time. When fading is not active, the new target is applied on the next clock.

The applied duty is linear. For channels with the curve select set, it then passes through a perceptual exponential map before the comparator. A tick input advances both the period counter and the fade time base. The parameter `UNIT_TICKS` sets how many ticks make one 50 ms fade unit. The applied linear duty of every channel is also driven out, so a neighbouring block can follow the fades.

Top module: `fade_pwm_dimmer`

## Requirements
- R1: The period counter covers 256 ticks. While the applied mapped duty is below 0xFF, an output is high in exactly that many of the 256 ticks of a period. A duty of 0 never drives the output high.
- R2: A mapped duty of 0xFF holds the output high on every cycle of the period.
- R3: The period counter advances once per cycle in which tick is 1, and holds in other cycles. While the global enable is 0, the counter is held at zero and every output is low.
- R4: A channel whose output enable is 0 drives a low output whatever its duty.
- R5: For a channel with fading inactive, the applied level equals the target one clock after the target is presented. The reset value of the applied level is 0.
- R6: The time code selects a fade length in 50 ms units. Codes 0 to 10 give 0 to 10 units. Codes 11, 12, 13, 14 and 15 give 20, 40, 80, 120 and 160 units. The length in ticks is T = units × UNIT_TICKS. Code 0 makes fading inactive even when the fade enable is 1.
- R7: A fade starts on the clock after the target changes, from the present level, with distance D = |target − level|. When D ≤ T, after n counted ticks the level has moved floor(D·n/T) LSBs toward the target, and it arrives exactly T ticks after the start.
- R8: When D > T, the level moves one LSB on every tick, so the fade lasts D ticks.
- R9: A target change during a fade restarts the fade from the level present at that moment, using the new distance and the full length T.
- R10: With the curve select set, the mapped duty for level x is floor(((32 + (x mod 32)) · 2^(x div 32) − 32) · 255 / 8032). This gives 0 for 0 and 255 for 255. With the select clear, the mapped duty equals x.
- R11: `level_o` carries the linear applied level, before the curve, with channel c in bits [8c+7:8c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base pulse for the counter and the fades |
| glob_en_i | input | 1 | Global enable |
| out_en_i | input | NCH | Per-channel output enable |
| fade_en_i | input | NCH | Per-channel fade enable |
| exp_en_i | input | NCH | Per-channel exponential curve select |
| fade_code_i | input | 4 | Fade length code |
| target_i | input | NCH*DW | Packed target duty bytes |
| pwm_o | output | NCH | PWM outputs |
| level_o | output | NCH*DW | Packed applied linear levels |

## Verification
The bench sweeps all 256 duty bytes on four channels at once, each channel set up differently, and counts high cycles over a full period. A comparator that is off by one would show up here, as would a 0xFF that is not forced high or a misplaced segment in the curve. The fade tests count the clocks from a target change to arrival for short, long, upward and downward fades. A wrong entry in the time-code table or an accumulator that drops remainders would change these counts. A restart that went back to the old start point would also change them. Sparse ticks, the global enable and a fade distance longer than the fade length are each checked, because a counter that ignores the tick or a fade that stalls when D > T only shows at those points.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

   localparam int CODE_W = 4;

   // fade length in 50 ms units for each time code
   function automatic int code_units(input logic [CODE_W-1:0] c);
      case (c)
         4'hB:    return 20;
         4'hC:    return 40;
         4'hD:    return 80;
         4'hE:    return 120;
         4'hF:    return 160;
         default: return int'(c);
      endcase
   endfunction

   // piecewise-linear 2^(x/32), rescaled so that 0->0 and 255->255
   function automatic logic [7:0] exp_curve(input logic [7:0] x);
      logic [15:0] e;
      logic [23:0] num;
      e   = 16'({1'b1, x[4:0]}) << x[7:5];
      num = 24'(e - 16'd32) * 24'd255;
      return 8'(num / 24'd8032);
   endfunction

endpackage

// File: rtl/dim_period_ctr.sv
module dim_period_ctr #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run_i,
   input  logic          tick_i,
   output logic [DW-1:0] cnt_o
);

   always_ff @(posedge clk) begin
      if (rst || !run_i)
         cnt_o <= '0;
      else if (tick_i)
         cnt_o <= cnt_o + 1'b1;
   end

   // R3
   ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i && tick_i) |=> (cnt_o == DW'($past(cnt_o) + 1'b1)));

   // R3
   ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i && !tick_i) |=> $stable(cnt_o));

   // R3
   ctr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !run_i |=> (cnt_o == '0));

endmodule

// File: rtl/dim_ramp.sv
module dim_ramp #(
   parameter int DW         = 8,
   parameter int UNIT_TICKS = 50
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      tick_i,
   input  logic                      fade_en_i,
   input  logic [fpd_pkg::CODE_W-1:0] code_i,
   input  logic [DW-1:0]             target_i,
   output logic [DW-1:0]             level_o
);

   localparam int MAX_SPAN = 160 * UNIT_TICKS;
   localparam int AW       = $clog2(MAX_SPAN + (1 << DW)) + 1;

   logic [DW-1:0] level_q, last_q, delta_q, dist_w;
   logic [AW-1:0] acc_q, acc_sum_w, span_w;
   logic          ramp_q, fade_act_w, restart_w, up_w;

   assign fade_act_w = fade_en_i && (code_i != '0);
   assign span_w     = AW'(fpd_pkg::code_units(code_i) * UNIT_TICKS);
   assign up_w       = target_i > level_q;
   assign dist_w     = up_w ? (target_i - level_q) : (level_q - target_i);
   assign restart_w  = (target_i != last_q) || (!ramp_q && (level_q != target_i));
   assign acc_sum_w  = acc_q + AW'(delta_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
         last_q  <= '0;
         delta_q <= '0;
         acc_q   <= '0;
         ramp_q  <= 1'b0;
      end else begin
         last_q <= target_i;
         if (!fade_act_w) begin
            level_q <= target_i;
            ramp_q  <= 1'b0;
            acc_q   <= '0;
         end else if (restart_w) begin
            ramp_q  <= (dist_w != '0);
            delta_q <= dist_w;
            acc_q   <= '0;
         end else if (ramp_q && tick_i) begin
            if (level_q == target_i) begin
               ramp_q <= 1'b0;
            end else if (AW'(delta_q) > span_w) begin
               level_q <= up_w ? level_q + 1'b1 : level_q - 1'b1;
            end else if (acc_sum_w >= span_w) begin
               level_q <= up_w ? level_q + 1'b1 : level_q - 1'b1;
               acc_q   <= acc_sum_w - span_w;
            end else begin
               acc_q   <= acc_sum_w;
            end
         end
      end
   end

   assign level_o = level_q;

   // R7
   ramp_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      fade_act_w |=> ((level_o == $past(level_o)) ||
                      (level_o == DW'($past(level_o) + 1'b1)) ||
                      (level_o == DW'($past(level_o) - 1'b1))));

   // R5
   jump_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !fade_act_w |=> (level_o == $past(target_i)));

   // R7
   no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
      (fade_act_w && !restart_w && (level_q == target_i)) |=> (level_o == $past(target_i)));

endmodule

// File: rtl/dim_out.sv
module dim_out #(
   parameter int DW          = 8,
   parameter bit EXP_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run_i,
   input  logic          exp_en_i,
   input  logic [DW-1:0] level_i,
   input  logic [DW-1:0] cnt_i,
   output logic          pwm_o
);

   logic [DW-1:0] duty_w;
   logic          hi_w;

   generate
      if (EXP_SUPPORT) begin : g_curve
         assign duty_w = exp_en_i ? fpd_pkg::exp_curve(level_i) : level_i;
      end else begin : g_linear
         assign duty_w = level_i;
      end
   endgenerate

   assign hi_w = (duty_w == '1) || (cnt_i < duty_w);

   always_ff @(posedge clk) begin
      if (rst)
         pwm_o <= 1'b0;
      else
         pwm_o <= run_i && hi_w;
   end

   // R4
   gated_low_chk: assert property (@(posedge clk) disable iff (rst)
      !run_i |=> !pwm_o);

   // R2
   full_on_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i && (duty_w == '1)) |=> pwm_o);

   // R1
   zero_off_chk: assert property (@(posedge clk) disable iff (rst)
      (duty_w == '0) |=> !pwm_o);

   // R10
   always_comb begin
      curve_ends_chk: assert (fpd_pkg::exp_curve(8'h00) == 8'h00 &&
                              fpd_pkg::exp_curve(8'hFF) == 8'hFF);
   end

endmodule

// File: rtl/fade_pwm_dimmer.sv
module fade_pwm_dimmer #(
   parameter int NCH         = 4,
   parameter int DW          = 8,
   parameter int UNIT_TICKS  = 50,
   parameter bit EXP_SUPPORT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      tick_i,
   input  logic                      glob_en_i,
   input  logic [NCH-1:0]            out_en_i,
   input  logic [NCH-1:0]            fade_en_i,
   input  logic [NCH-1:0]            exp_en_i,
   input  logic [fpd_pkg::CODE_W-1:0] fade_code_i,
   input  logic [NCH*DW-1:0]         target_i,
   output logic [NCH-1:0]            pwm_o,
   output logic [NCH*DW-1:0]         level_o
);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
      if (DW != 8) begin : g_bad_dw
         $error("DW must be 8: the period and curve are byte based");
      end
      if (UNIT_TICKS < 1) begin : g_bad_unit
         $error("UNIT_TICKS must be at least 1");
      end
   endgenerate

   logic [DW-1:0] cnt;

   dim_period_ctr #(.DW(DW)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .run_i (glob_en_i),
      .tick_i(tick_i),
      .cnt_o (cnt)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [DW-1:0] lvl;

      dim_ramp #(.DW(DW), .UNIT_TICKS(UNIT_TICKS)) u_ramp (
         .clk      (clk),
         .rst      (rst),
         .tick_i   (tick_i),
         .fade_en_i(fade_en_i[g]),
         .code_i   (fade_code_i),
         .target_i (target_i[g*DW +: DW]),
         .level_o  (lvl)
      );

      dim_out #(.DW(DW), .EXP_SUPPORT(EXP_SUPPORT)) u_out (
         .clk     (clk),
         .rst     (rst),
         .run_i   (glob_en_i && out_en_i[g]),
         .exp_en_i(exp_en_i[g]),
         .level_i (lvl),
         .cnt_i   (cnt),
         .pwm_o   (pwm_o[g])
      );

      assign level_o[g*DW +: DW] = lvl;
   end

endmodule

// File: tb/tb_fade_pwm_dimmer.sv
`timescale 1ns/1ps
module tb_fade_pwm_dimmer;

   localparam int NCH  = 4;
   localparam int DW   = 8;
   localparam int UNIT = 32;

   logic              clk = 1'b0, rst = 1'b1, tick = 1'b1, glob_en = 1'b0;
   logic [NCH-1:0]    out_en = '0, fade_en = '0, exp_en = '0;
   logic [3:0]        code = '0;
   logic [NCH*DW-1:0] target = '0;
   logic [NCH-1:0]    pwm;
   logic [NCH*DW-1:0] level;

   int errs = 0, checks = 0;
   int hc [NCH];

   always #2.5 clk = ~clk;

   fade_pwm_dimmer #(.NCH(NCH), .DW(DW), .UNIT_TICKS(UNIT)) dut (
      .clk(clk), .rst(rst), .tick_i(tick), .glob_en_i(glob_en),
      .out_en_i(out_en), .fade_en_i(fade_en), .exp_en_i(exp_en),
      .fade_code_i(code), .target_i(target), .pwm_o(pwm), .level_o(level)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   function automatic int tb_units(input int c);
      if (c <= 10) return c;
      case (c)
         11: return 20;
         12: return 40;
         13: return 80;
         14: return 120;
         default: return 160;
      endcase
   endfunction

   function automatic int tb_exp(input int x);
      int e;
      e = (32 + (x % 32)) * (1 << (x / 32));
      return ((e - 32) * 255) / 8032;
   endfunction

   function automatic int highs_of(input int duty);
      return (duty == 255) ? 256 : duty;
   endfunction

   task automatic set_all(input int v);
      for (int c = 0; c < NCH; c++) target[c*DW +: DW] = DW'(v);
   endtask

   task automatic measure(input int n);
      for (int c = 0; c < NCH; c++) hc[c] = 0;
      repeat (n) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) if (pwm[c]) hc[c]++;
      end
   endtask

   // drive channel 0 target at a negedge, count clocks until arrival
   task automatic ramp_len(input int v, output int k);
      target[DW-1:0] = DW'(v);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (int'(level[DW-1:0]) != v && k < 30000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R5 reset level", int'(level[DW-1:0]), 0);
      chk("R1 reset outputs", int'(pwm), 0);

      // sweep: ch0 linear, ch1 curve, ch2 disabled, ch3 fade on with code 0
      glob_en = 1'b1;
      out_en  = 4'b1011;
      exp_en  = 4'b0010;
      fade_en = 4'b1000;
      code    = 4'h0;
      for (int d = 0; d < 256; d++) begin
         set_all(d);
         repeat (3) @(negedge clk);
         measure(256);
         chk((d == 255) ? "R2 full duty ch0" : "R1 linear duty ch0", hc[0], highs_of(d));
         chk("R10 curve duty ch1", hc[1], highs_of(tb_exp(d)));
         chk("R4 disabled ch2", hc[2], 0);
         chk("R6 code 0 jumps ch3", hc[3], highs_of(d));
         chk("R11 linear level ch1", int'(level[DW +: DW]), d);
      end

      // R3 global enable off
      glob_en = 1'b0;
      repeat (3) @(negedge clk);
      measure(256);
      chk("R3 global off ch0", hc[0], 0);
      chk("R3 global off ch1", hc[1], 0);
      glob_en = 1'b1;

      // R3 tick every other cycle doubles the high count
      set_all(100);
      repeat (3) @(negedge clk);
      repeat (10) begin
         @(negedge clk);
         tick = ~tick;
      end
      k = 0;
      repeat (512) begin
         @(negedge clk);
         if (pwm[0]) k++;
         tick = ~tick;
      end
      chk("R3 sparse tick ch0", k, 200);
      tick = 1'b1;

      // R5 fade disabled: level follows on the next clock
      target[DW-1:0] = 8'd77;
      @(negedge clk);
      chk("R5 jump in one clock", int'(level[DW-1:0]), 77);

      // fade tests on ch0
      target[DW-1:0] = 8'd0;
      repeat (3) @(negedge clk);
      fade_en[0] = 1'b1;
      code = 4'hA;
      repeat (2) @(negedge clk);

      target[DW-1:0] = 8'd200;
      repeat (161) @(negedge clk);
      chk("R7 midpoint level", int'(level[DW-1:0]), (200 * 160) / (tb_units(10) * UNIT));
      ramp_len(60, k);
      chk("R9 restart length", k, tb_units(10) * UNIT + 1);

      code = 4'hD;
      @(negedge clk);
      ramp_len(0, k);
      chk("R7 down fade length code 13", k, tb_units(13) * UNIT + 1);

      code = 4'h1;
      @(negedge clk);
      ramp_len(255, k);
      chk("R8 distance above length", k, 255 + 1);

      code = 4'hB;
      @(negedge clk);
      ramp_len(215, k);
      chk("R6 fade length code 11", k, tb_units(11) * UNIT + 1);

      code = 4'hF;
      @(negedge clk);
      ramp_len(15, k);
      chk("R6 fade length code 15", k, tb_units(15) * UNIT + 1);

      code = 4'h0;
      @(negedge clk);
      target[DW-1:0] = 8'd180;
      @(negedge clk);
      chk("R6 code 0 with fade on", int'(level[DW-1:0]), 180);

      finish_run();
   end

endmodule